// File: doc/BRIEF.md
# SD Host Normal Interrupt Status Register

This block keeps five sticky interrupt flags for an SD host controller. Each flag is raised by a transition or a pulse on a status line inside the controller: card presence, buffer read readiness, buffer write readiness, the DMA boundary marker, and the end of a transfer that was halted at a block gap. A flag stays set until software writes a 1 to its bit position through a single 16-bit register port.

The block-gap flag is the only one with a qualified source. It is raised only while the stop-at-gap request is held. For read transfers its source is the falling edge of the DAT-line-active line. For write transfers its source is the falling edge of the write-transfer-active line. Each flag is ANDed with a bit of an enable vector, and the results are ORed into one interrupt output.

Every edge source is compared against a registered copy of itself. Edge detection is disarmed for the first clock after reset, so a line that is already high when reset ends does not raise a flag.

Top module: `sd_irq_status_reg`

## Requirements
- R1: Bit 6 of `rd_data` is set one clock after a 0-to-1 transition of `card_in`.
- R2: Bit 5 is set one clock after a 0-to-1 transition of `rd_buf_en`.
- R3: Bit 4 is set one clock after a 0-to-1 transition of `wr_buf_en`.
- R4: Bit 3 is set one clock after any cycle in which `dma_bnd_pulse` is 1.
- R5: When `gap_stop_req` is 1 and `xfer_is_read` is 1, a 1-to-0 transition of `dat_active` sets bit 2. In that mode a fall of `wr_xfer_active` does not set bit 2.
- R6: When `gap_stop_req` is 1 and `xfer_is_read` is 0, a 1-to-0 transition of `wr_xfer_active` sets bit 2. In that mode a fall of `dat_active` does not set bit 2.
- R7: While `gap_stop_req` is 0, no fall on either transfer line sets bit 2.
- R8: A cycle with `wr_en` at 1 clears every status bit whose `wr_data` bit is 1. Bits whose `wr_data` bit is 0 are left unchanged, and no bit changes while `wr_en` is 0.
- R9: If a set event and a write-1 clear hit the same bit in the same cycle, the bit reads 1 afterwards.
- R10: All bits read 0 after reset. Bits 15 to 7 and 1 to 0 always read 0, including after writes to them.
- R11: `irq` is 1 exactly when some bit of `rd_data` is 1 and the same bit of `irq_en` is 1.
- R12: A source level that is already 1 on the first clock after reset does not set its bit. A level held at 1 sets its bit only once, so after a clear the bit stays 0 until a new 0-to-1 transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| card_in | input | 1 | Card-present status |
| rd_buf_en | input | 1 | Buffer readable status |
| wr_buf_en | input | 1 | Buffer writable status |
| dma_bnd_pulse | input | 1 | DMA buffer boundary reached, one pulse per event |
| dat_active | input | 1 | DAT line busy status |
| wr_xfer_active | input | 1 | Write transfer in progress |
| gap_stop_req | input | 1 | Stop-at-block-gap request pending |
| xfer_is_read | input | 1 | Transfer direction: 1 means read, 0 means write |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Write data, 1 clears the matching bit |
| irq_en | input | 16 | Per-bit interrupt enable |
| rd_data | output | 16 | Current status register value |
| irq | output | 1 | OR of the enabled status bits |

## Verification
The bench holds `card_in` high through reset and checks that no flag appears, because a design that primes its edge detector with 0 would report a card insertion at power-up. It collides a rising edge with a write-1 clear of the same bit; a design that gives the clear priority would silently lose the event. It swaps the transfer direction while producing falls on the wrong line, and it drops the gap request, to catch a block-gap source that ignores the direction or the request. It also keeps a level high across a clear, which catches a level-sensitive set that would re-raise the flag straight away.

// File: rtl/sdirq_pkg.sv
package sdirq_pkg;
  localparam int unsigned REG_W   = 16;
  localparam int unsigned B_CARD  = 6;
  localparam int unsigned B_RDRDY = 5;
  localparam int unsigned B_WRRDY = 4;
  localparam int unsigned B_DMA   = 3;
  localparam int unsigned B_GAP   = 2;

  // Bit positions that hold a real flag
  function automatic logic [REG_W-1:0] live_mask();
    logic [REG_W-1:0] m;
    m = '0;
    m[B_CARD]  = 1'b1;
    m[B_RDRDY] = 1'b1;
    m[B_WRRDY] = 1'b1;
    m[B_DMA]   = 1'b1;
    m[B_GAP]   = 1'b1;
    return m;
  endfunction

  // Sticky update: a write of 1 clears a bit, and a set event overrides the clear
  function automatic logic [REG_W-1:0] next_status(
    input logic [REG_W-1:0] cur,
    input logic [REG_W-1:0] set_v,
    input logic             wen,
    input logic [REG_W-1:0] wdat
  );
    logic [REG_W-1:0] clr;
    clr = wen ? wdat : '0;
    return ((cur & ~clr) | set_v) & live_mask();
  endfunction
endpackage

// File: rtl/sdirq_edge_det.sv
module sdirq_edge_det #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall,
  output logic         armed
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      armed  <= 1'b0;
    end else begin
      prev_q <= sig;
      armed  <= 1'b1;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign rise[i] = armed &  sig[i] & ~prev_q[i];
    assign fall[i] = armed & ~sig[i] &  prev_q[i];
  end
endmodule

// File: rtl/sdirq_gap_sel.sv
module sdirq_gap_sel (
  input  logic req,
  input  logic is_read,
  input  logic dat_fall,
  input  logic wr_fall,
  output logic gap_evt
);
  always_comb begin
    gap_evt = 1'b0;
    if (req) gap_evt = is_read ? dat_fall : wr_fall;
  end
endmodule

// File: rtl/sdirq_status_bits.sv
module sdirq_status_bits
  import sdirq_pkg::*;
#(
  parameter int unsigned W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_v,
  input  logic         wen,
  input  logic [W-1:0] wdat,
  output logic [W-1:0] status
);
  localparam logic [W-1:0] LIVE = live_mask();

  logic [W-1:0] nxt;
  assign nxt = next_status(status, set_v, wen, wdat);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (LIVE[i]) begin : g_live
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status[i] <= 1'b0;
        else        status[i] <= nxt[i];
      end
    end else begin : g_dead
      assign status[i] = 1'b0;
    end
  end
endmodule

// File: rtl/sd_irq_status_reg.sv
module sd_irq_status_reg
  import sdirq_pkg::*;
#(
  parameter int unsigned W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         card_in,
  input  logic         rd_buf_en,
  input  logic         wr_buf_en,
  input  logic         dma_bnd_pulse,
  input  logic         dat_active,
  input  logic         wr_xfer_active,
  input  logic         gap_stop_req,
  input  logic         xfer_is_read,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] irq_en,
  output logic [W-1:0] rd_data,
  output logic         irq
);
  localparam int unsigned NSRC  = 5;
  localparam int unsigned S_CRD = 0;
  localparam int unsigned S_RDB = 1;
  localparam int unsigned S_WRB = 2;
  localparam int unsigned S_DAT = 3;
  localparam int unsigned S_WXF = 4;

  logic [NSRC-1:0] src, rise, fall;
  logic            armed;
  logic            card_rise, rdbuf_rise, wrbuf_rise, gap_evt;
  logic [W-1:0]    set_v;

  assign src[S_CRD] = card_in;
  assign src[S_RDB] = rd_buf_en;
  assign src[S_WRB] = wr_buf_en;
  assign src[S_DAT] = dat_active;
  assign src[S_WXF] = wr_xfer_active;

  sdirq_edge_det #(.N(NSRC)) u_edge (
    .clk(clk), .rst_n(rst_n), .sig(src), .rise(rise), .fall(fall), .armed(armed)
  );

  assign card_rise  = rise[S_CRD];
  assign rdbuf_rise = rise[S_RDB];
  assign wrbuf_rise = rise[S_WRB];

  sdirq_gap_sel u_gap (
    .req(gap_stop_req), .is_read(xfer_is_read),
    .dat_fall(fall[S_DAT]), .wr_fall(fall[S_WXF]), .gap_evt(gap_evt)
  );

  always_comb begin
    set_v          = '0;
    set_v[B_CARD]  = card_rise;
    set_v[B_RDRDY] = rdbuf_rise;
    set_v[B_WRRDY] = wrbuf_rise;
    set_v[B_DMA]   = dma_bnd_pulse;
    set_v[B_GAP]   = gap_evt;
  end

  sdirq_status_bits #(.W(W)) u_bits (
    .clk(clk), .rst_n(rst_n), .set_v(set_v), .wen(wr_en), .wdat(wr_data), .status(rd_data)
  );

  assign irq = |(rd_data & irq_en);

  logic unused_armed;
  assign unused_armed = armed;
endmodule

// File: rtl/sdirq_chk.sv
module sdirq_chk
  import sdirq_pkg::*;
#(
  parameter int unsigned W = REG_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] irq_en,
  input logic [W-1:0] rd_data,
  input logic         irq,
  input logic         dma_bnd_pulse,
  input logic         gap_stop_req,
  input logic         card_rise
);
  localparam logic [W-1:0] LIVE = live_mask();

  AST_CARD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    card_rise |=> rd_data[B_CARD]); // R1
  AST_DMA_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    dma_bnd_pulse |=> rd_data[B_DMA]); // R4
  AST_GAP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[B_GAP]) |-> $past(gap_stop_req)); // R7
  AST_NO_SILENT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((rd_data & $past(rd_data)) == $past(rd_data))); // R8
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (card_rise && wr_en && wr_data[B_CARD]) |=> rd_data[B_CARD]); // R9
  AST_DEAD_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~LIVE) == '0); // R10
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data == '0) |-> !irq); // R11
  AST_IRQ_ALL_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_en == '1) && (rd_data != '0)) |-> irq); // R11
endmodule

bind sd_irq_status_reg sdirq_chk #(.W(W)) u_chk (.*);

// File: tb/sim_sd_irq_status_reg.sv
module sim_sd_irq_status_reg;
  localparam time CLK_PER = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        card_in = 0, rd_buf_en = 0, wr_buf_en = 0, dma_bnd_pulse = 0;
  logic        dat_active = 0, wr_xfer_active = 0, gap_stop_req = 0, xfer_is_read = 0;
  logic        wr_en = 0;
  logic [15:0] wr_data = '0, irq_en = '0;
  logic [15:0] rd_data;
  logic        irq;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference state
  int m_stat = 0;
  bit m_armed = 0;
  bit p_card = 0, p_rdb = 0, p_wrb = 0, p_dat = 0, p_wxf = 0;

  always #(CLK_PER/2) clk = ~clk;

  sd_irq_status_reg u0 (
    .clk(clk), .rst_n(rst_n), .card_in(card_in), .rd_buf_en(rd_buf_en),
    .wr_buf_en(wr_buf_en), .dma_bnd_pulse(dma_bnd_pulse), .dat_active(dat_active),
    .wr_xfer_active(wr_xfer_active), .gap_stop_req(gap_stop_req),
    .xfer_is_read(xfer_is_read), .wr_en(wr_en), .wr_data(wr_data),
    .irq_en(irq_en), .rd_data(rd_data), .irq(irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat = 0; m_armed = 0;
      p_card = 0; p_rdb = 0; p_wrb = 0; p_dat = 0; p_wxf = 0;
    end else begin
      int ev;
      ev = 0;
      if (m_armed) begin
        if (card_in && !p_card)    ev += 64;
        if (rd_buf_en && !p_rdb)   ev += 32;
        if (wr_buf_en && !p_wrb)   ev += 16;
        if (gap_stop_req) begin
          if (xfer_is_read  && p_dat && !dat_active)     ev += 4;
          if (!xfer_is_read && p_wxf && !wr_xfer_active) ev += 4;
        end
      end
      if (dma_bnd_pulse) ev = ev | 8;
      if (wr_en) m_stat = m_stat & ~int'(wr_data);
      m_stat = (m_stat | ev) & 'h7C;
      p_card = card_in; p_rdb = rd_buf_en; p_wrb = wr_buf_en;
      p_dat = dat_active; p_wxf = wr_xfer_active;
      m_armed = 1;
    end
  end

  function automatic string tag_of(int b);
    case (b)
      6: return "R1";
      5: return "R2";
      4: return "R3";
      3: return "R4";
      2: return "R5";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare against the reference model every clock, away from the edge
  always @(negedge clk) if (rst_n && !done) begin
    for (int b = 0; b < 16; b++) check(tag_of(b), int'(rd_data[b]), (m_stat >> b) & 1);
    check("R11", int'(irq), int'((m_stat & int'(irq_en)) != 0));
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic clr_all();
    tick(); wr_en = 1; wr_data = 16'hFFFF;
    tick(); wr_en = 0; wr_data = '0;
  endtask

  initial begin
    irq_en = 16'hFFFF;
    card_in = 1; rd_buf_en = 1;
    repeat (3) tick();
    check("R10", int'(rd_data), 0);
    rst_n = 1;
    repeat (3) tick();
    check("R12", int'(rd_data[6]), 0);
    check("R12", int'(rd_data[5]), 0);

    // R1 fresh insertion, then clear
    card_in = 0; tick(); card_in = 1; tick();
    check("R1", int'(rd_data[6]), 1);
    wr_en = 1; wr_data = 16'h0040; tick(); wr_en = 0; wr_data = '0;
    check("R8", int'(rd_data[6]), 0);
    tick();
    check("R12", int'(rd_data[6]), 0); // level still high, no re-set

    // R8 write of 0 and writes to dead bits
    dma_bnd_pulse = 1; tick(); dma_bnd_pulse = 0;
    check("R4", int'(rd_data[3]), 1);
    wr_en = 1; wr_data = 16'hFF83; tick(); wr_en = 0; wr_data = '0;
    check("R8", int'(rd_data[3]), 1);
    check("R10", int'(rd_data & 16'hFF83), 0);

    // R9 set and clear collide
    card_in = 0; tick();
    card_in = 1; wr_en = 1; wr_data = 16'h0040; tick(); wr_en = 0; wr_data = '0;
    check("R9", int'(rd_data[6]), 1);
    clr_all();

    // R5 read direction: wrong-line fall ignored, DAT fall sets
    gap_stop_req = 1; xfer_is_read = 1;
    wr_xfer_active = 1; tick(); wr_xfer_active = 0; tick(); tick();
    check("R5", int'(rd_data[2]), 0);
    dat_active = 1; tick(); dat_active = 0; tick();
    check("R5", int'(rd_data[2]), 1);
    clr_all();

    // R6 write direction
    xfer_is_read = 0;
    dat_active = 1; tick(); dat_active = 0; tick(); tick();
    check("R6", int'(rd_data[2]), 0);
    wr_xfer_active = 1; tick(); wr_xfer_active = 0; tick();
    check("R6", int'(rd_data[2]), 1);
    clr_all();

    // R7 no request
    gap_stop_req = 0;
    dat_active = 1; wr_xfer_active = 1; tick();
    dat_active = 0; wr_xfer_active = 0; tick(); tick();
    check("R7", int'(rd_data[2]), 0);

    // R2 / R3 buffer ready rises, R11 masking
    rd_buf_en = 0; wr_buf_en = 0; tick();
    rd_buf_en = 1; wr_buf_en = 1; irq_en = 16'h0020; tick();
    check("R2", int'(rd_data[5]), 1);
    check("R3", int'(rd_data[4]), 1);
    check("R11", int'(irq), 1);
    irq_en = 16'h0F0F; tick();
    check("R11", int'(irq), 0);
    clr_all();

    // pseudo-random traffic, checked by the per-clock comparison
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom);
      card_in = r[0]; rd_buf_en = r[1]; wr_buf_en = r[2];
      dma_bnd_pulse = (r[5:3] == 0);
      dat_active = r[6]; wr_xfer_active = r[7];
      gap_stop_req = r[8] | r[9]; xfer_is_read = r[10];
      wr_en = (r[13:11] == 0); wr_data = r[31:16];
      irq_en = 16'(r[27:12]);
      tick();
    end
    wr_en = 0;
    tick();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule